// File: doc/BRIEF.md
# Reservation-Table Scheduler for a Three-Stage Reconfigurable Pipeline

This block sequences a three-stage pipeline whose stages (Sa, Sb, Sc) are visited more than once by a single operation. Each stage has an output latch. A multiplexer in front of each stage selects one of four sources: the external operand or the latch of any of the three stages. Two operation kinds exist. Kind A visits Sa, Sb, Sc, Sb, Sc, Sa. Kind B visits Sa, Sc, Sb, Sa, Sb, Sc. Each visit takes one clock, so a result is ready six clocks after launch.

Launch requests arrive on a valid/ready handshake that carries a one-bit kind and an operand. The block keeps a per-stage bitmap of the clocks already booked by operations in flight. A request is admitted only if its own booking pattern does not overlap that bitmap. In overlap mode, operations of both kinds may run together. In drain mode, a change of kind waits until every booking has expired. The stage arithmetic is a placeholder:

- Sa: add one
- Sb: rotate left by one
- Sc: XOR with a mask, 0x3C by default

Top module: `rt_pipe_ctrl`

## Requirements
- R1: A synchronous reset clears all bookings and latches. In the clock after reset, both result valids and all stage enables are low, and `req_ready` is high.
- R2: A kind-A operation launched in clock k enables Sa, Sb, Sc, Sb, Sc, Sa in clocks k to k+5. The select of each visit names the source: 0 is the external operand, 1 the Sa latch, 2 the Sb latch, 3 the Sc latch. The visit in clock k uses 0, and every later visit uses the latch of the previous stage in the sequence.
- R3: A kind-B operation launched in clock k enables Sa, Sc, Sb, Sa, Sb, Sc in clocks k to k+5, with selects encoded as in R2.
- R4: A kind-A result (`req_func`=0) appears on `out_a_valid`/`out_a_data` exactly 6 clocks after launch. Its value is the operand passed through the stage transforms in kind-A order.
- R5: A kind-B result (`req_func`=1) appears on `out_b_valid`/`out_b_data` exactly 6 clocks after launch. Its value is the operand passed through the transforms in kind-B order.
- R6: In overlap mode (`mode_dyn`=1), `req_ready` is low exactly when the candidate would use some stage in the same clock as an operation already admitted. Taken alone, this refuses kind A at spacings 2 and 5, and kind B at spacings 2, 3 and 4.
- R7: In drain mode (`mode_dyn`=0), a request whose kind differs from the last admitted kind is refused while any booking remains. After reset, the first request of either kind is accepted.
- R8: In drain mode, a request of the same kind is still refused when its stages would be double-booked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_dyn | input | 1 | 1 = overlap mode, 0 = drain mode |
| req_valid | input | 1 | Launch request present |
| req_func | input | 1 | Kind: 0 = A, 1 = B |
| req_data | input | W | Operand |
| req_ready | output | 1 | Request can be admitted this clock |
| en_a | output | 1 | Sa in use this clock |
| en_b | output | 1 | Sb in use this clock |
| en_c | output | 1 | Sc in use this clock |
| sel_a | output | 2 | Sa input select |
| sel_b | output | 2 | Sb input select |
| sel_c | output | 2 | Sc input select |
| out_a_valid | output | 1 | Kind-A result valid |
| out_a_data | output | W | Kind-A result |
| out_b_valid | output | 1 | Kind-B result valid |
| out_b_data | output | W | Kind-B result |

## Verification
The bench streams launches of each kind back to back to expose the forbidden spacings. A bitmap shifted the wrong way, or a booking pattern with one wrong bit, would admit a request at spacing 2. Two operations would then enable the same stage in one clock, and a result would come out corrupted or one clock off. Random mixes of both kinds check cross-kind collisions, which a check per kind would miss. Runs in drain mode with rare kind changes show whether a design tests only the current clock's occupancy rather than all future bookings, since such a design would switch kinds while work is still in flight. A reset in the middle of traffic checks that no stale booking or latch survives to produce a phantom result.

// File: rtl/rt_pipe_ctrl.sv
module rt_pipe_ctrl #(
  parameter int W = 8,
  parameter logic [W-1:0] C_MASK = W'(60)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_dyn,
  input  logic         req_valid,
  input  logic         req_func,
  input  logic [W-1:0] req_data,
  output logic         req_ready,
  output logic         en_a,
  output logic         en_b,
  output logic         en_c,
  output logic [1:0]   sel_a,
  output logic [1:0]   sel_b,
  output logic [1:0]   sel_c,
  output logic         out_a_valid,
  output logic [W-1:0] out_a_data,
  output logic         out_b_valid,
  output logic [W-1:0] out_b_data
);
  localparam int NS = 3;
  localparam int NT = 6;
  localparam int SW = $clog2(NT);
  localparam logic [SW-1:0] LAST = SW'(NT - 1);

  function automatic logic [1:0] use_of(input logic f, input logic [SW-1:0] t);
    case (t)
      SW'(0):  use_of = 2'd0;
      SW'(1):  use_of = f ? 2'd2 : 2'd1;
      SW'(2):  use_of = f ? 2'd1 : 2'd2;
      SW'(3):  use_of = f ? 2'd0 : 2'd1;
      SW'(4):  use_of = f ? 2'd1 : 2'd2;
      default: use_of = f ? 2'd2 : 2'd0;
    endcase
  endfunction

  function automatic logic [NT-1:0] claim(input logic f, input int s);
    claim = '0;
    for (int t = 0; t < NT; t++)
      if (int'(use_of(f, SW'(t))) == s) claim[t] = 1'b1;
  endfunction

  function automatic logic [W-1:0] xform(input int s, input logic [W-1:0] d);
    case (s)
      0:       xform = d + W'(1);
      1:       xform = {d[W-2:0], d[W-1]};
      default: xform = d ^ C_MASK;
    endcase
  endfunction

  logic [NT-1:0] occ   [NS];
  logic          lat_v [NS];
  logic          lat_f [NS];
  logic [SW-1:0] lat_t [NS];
  logic [W-1:0]  lat_d [NS];
  logic          en    [NS];
  logic [1:0]    sel   [NS];
  logic          last_f;
  logic          hit, empty, acc;

  always_comb begin
    hit   = 1'b0;
    empty = 1'b1;
    for (int s = 0; s < NS; s++) begin
      hit   = hit | (|(occ[s] & claim(req_func, s)));
      empty = empty & ~(|occ[s]);
    end
  end

  assign req_ready = !hit && (mode_dyn || empty || req_func == last_f);
  assign acc       = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst)      last_f <= 1'b0;
    else if (acc) last_f <= req_func;
  end

  generate
    for (genvar s = 0; s < NS; s++) begin : g_stage
      logic          en_l;
      logic [1:0]    sel_l;
      logic          f_l;
      logic [SW-1:0] t_l;
      logic [W-1:0]  src;
      logic [NT-1:0] occ_q;
      logic          v_q, f_q;
      logic [SW-1:0] t_q;
      logic [W-1:0]  d_q;

      always_comb begin
        en_l  = 1'b0;
        sel_l = 2'd0;
        f_l   = req_func;
        t_l   = '0;
        src   = req_data;
        if (s == 0 && acc) en_l = 1'b1;
        for (int x = 0; x < NS; x++) begin
          if (lat_v[x] && lat_t[x] != LAST &&
              int'(use_of(lat_f[x], lat_t[x] + SW'(1))) == s) begin
            en_l  = 1'b1;
            sel_l = 2'(x + 1);
            f_l   = lat_f[x];
            t_l   = lat_t[x] + SW'(1);
            src   = lat_d[x];
          end
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          v_q   <= 1'b0;
          occ_q <= '0;
        end else begin
          v_q   <= en_l;
          occ_q <= (occ_q | (acc ? claim(req_func, s) : '0)) >> 1;
        end
        f_q <= f_l;
        t_q <= t_l;
        d_q <= xform(s, src);
      end

      assign occ[s]   = occ_q;
      assign lat_v[s] = v_q;
      assign lat_f[s] = f_q;
      assign lat_t[s] = t_q;
      assign lat_d[s] = d_q;
      assign en[s]    = en_l;
      assign sel[s]   = sel_l;
    end
  endgenerate

  assign en_a  = en[0];
  assign en_b  = en[1];
  assign en_c  = en[2];
  assign sel_a = sel[0];
  assign sel_b = sel[1];
  assign sel_c = sel[2];

  assign out_a_valid = lat_v[0] && !lat_f[0] && lat_t[0] == LAST;
  assign out_a_data  = lat_d[0];
  assign out_b_valid = lat_v[2] && lat_f[2] && lat_t[2] == LAST;
  assign out_b_data  = lat_d[2];
endmodule

// File: rtl/rt_pipe_ctrl_chk.sv
module rt_pipe_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode_dyn,
  input logic       req_valid,
  input logic       req_func,
  input logic       req_ready,
  input logic       en_b,
  input logic       en_c,
  input logic [1:0] sel_b,
  input logic [1:0] sel_c,
  input logic       out_a_valid,
  input logic       out_b_valid
);
  logic       acc;
  logic [2:0] since;
  logic       lastk;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= 3'd6;
      lastk <= 1'b0;
    end else if (acc) begin
      since <= 3'd1;
      lastk <= req_func;
    end else if (since < 3'd6) begin
      since <= since + 3'd1;
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    rst |=> (!out_a_valid && !out_b_valid && !en_b && !en_c));

  // R2
  sb_src_chk: assert property (@(posedge clk) disable iff (rst)
    en_b |-> sel_b != 2'd0);

  // R3
  sc_src_chk: assert property (@(posedge clk) disable iff (rst)
    en_c |-> sel_c != 2'd0);

  // R4
  a_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_a_valid |-> $past(acc && !req_func, 6));

  // R5
  b_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_b_valid |-> $past(acc && req_func, 6));

  // R6
  a_gap2_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_func && !$past(rst) && !$past(rst, 2)) |-> !$past(acc && !req_func, 2));

  // R6
  b_gap3_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && req_func && !$past(rst) && !$past(rst, 2) && !$past(rst, 3))
      |-> !$past(acc && req_func, 3));

  // R7
  static_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !mode_dyn && req_func != lastk) |-> since == 3'd6);
endmodule

bind rt_pipe_ctrl rt_pipe_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .mode_dyn(mode_dyn), .req_valid(req_valid),
  .req_func(req_func), .req_ready(req_ready), .en_b(en_b), .en_c(en_c),
  .sel_b(sel_b), .sel_c(sel_c), .out_a_valid(out_a_valid), .out_b_valid(out_b_valid)
);

// File: tb/sim_rt_pipe_ctrl.sv
`timescale 1ns/1ps
module sim_rt_pipe_ctrl;
  localparam int MAXC = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_dyn = 1'b1;
  logic req_valid = 1'b0;
  logic req_func = 1'b0;
  logic [7:0] req_data = 8'h00;
  logic req_ready, en_a, en_b, en_c;
  logic [1:0] sel_a, sel_b, sel_c;
  logic out_a_valid, out_b_valid;
  logic [7:0] out_a_data, out_b_data;

  always #2.5 clk = ~clk;

  rt_pipe_ctrl u0 (
    .clk(clk), .rst(rst), .mode_dyn(mode_dyn), .req_valid(req_valid),
    .req_func(req_func), .req_data(req_data), .req_ready(req_ready),
    .en_a(en_a), .en_b(en_b), .en_c(en_c),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
    .out_a_valid(out_a_valid), .out_a_data(out_a_data),
    .out_b_valid(out_b_valid), .out_b_data(out_b_data)
  );

  int errors = 0;
  int checks = 0;
  int k = 0;
  int floor_c = 0;
  bit lastf = 1'b0;
  bit iv [MAXC];
  bit ifn [MAXC];
  logic [7:0] idt [MAXC];
  int seq_a [6] = '{0, 1, 2, 1, 2, 0};
  int seq_b [6] = '{0, 2, 1, 0, 1, 2};

  function automatic int sq(bit f, int j);
    return f ? seq_b[j] : seq_a[j];
  endfunction

  function automatic logic [7:0] xf(int s, logic [7:0] d);
    if (s == 0) return d + 8'd1;
    if (s == 1) return {d[6:0], d[7]};
    return d ^ 8'h3C;
  endfunction

  function automatic logic [7:0] run(bit f, logic [7:0] d);
    logic [7:0] r = d;
    for (int j = 0; j < 6; j++) r = xf(sq(f, j), r);
    return r;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, k, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic cyc(bit m, bit v, bit f, logic [7:0] d, bit r);
    bit hit, empty, rdy, acc, ea, eb;
    bit ee [3];
    int es [3];
    string et [3];
    int lo, i;
    @(negedge clk);
    rst = r; mode_dyn = m; req_valid = v; req_func = f; req_data = d;
    #1;
    if (r) begin
      floor_c = k + 1;
      lastf = 1'b0;
    end else begin
      hit = 0; empty = 1;
      lo = (k - 5 > floor_c) ? k - 5 : floor_c;
      for (int p = lo; p < k; p++) begin
        if (iv[p]) begin
          empty = 0;
          for (int o = 0; o < 6; o++)
            if (k + o - p <= 5 && sq(ifn[p], k + o - p) == sq(f, o)) hit = 1;
        end
      end
      rdy = !hit && (m || empty || f == lastf);
      chk(req_ready == rdy, hit ? (m ? "R6" : "R8") : "R7", req_ready, rdy);
      acc = v && rdy;
      if (acc) begin
        iv[k] = 1; ifn[k] = f; idt[k] = d; lastf = f;
      end
      for (int s = 0; s < 3; s++) begin ee[s] = 0; es[s] = 0; et[s] = "R2"; end
      for (int p = lo; p <= k; p++) begin
        if (iv[p]) begin
          ee[sq(ifn[p], k - p)] = 1;
          es[sq(ifn[p], k - p)] = (k == p) ? 0 : sq(ifn[p], k - p - 1) + 1;
          et[sq(ifn[p], k - p)] = ifn[p] ? "R3" : "R2";
        end
      end
      chk(en_a == ee[0], et[0], en_a, ee[0]);
      chk(en_b == ee[1], et[1], en_b, ee[1]);
      chk(en_c == ee[2], et[2], en_c, ee[2]);
      if (ee[0]) chk(int'(sel_a) == es[0], et[0], sel_a, es[0]);
      if (ee[1]) chk(int'(sel_b) == es[1], et[1], sel_b, es[1]);
      if (ee[2]) chk(int'(sel_c) == es[2], et[2], sel_c, es[2]);
      i = k - 6;
      ea = (i >= floor_c) && iv[i] && !ifn[i];
      eb = (i >= floor_c) && iv[i] && ifn[i];
      chk(out_a_valid == ea, "R4", out_a_valid, ea);
      chk(out_b_valid == eb, "R5", out_b_valid, eb);
      if (ea) chk(out_a_data == run(0, idt[i]), "R4", out_a_data, run(0, idt[i]));
      if (eb) chk(out_b_data == run(1, idt[i]), "R5", out_b_data, run(1, idt[i]));
    end
    k++;
  endtask

  task automatic r1_after_reset();
    cyc(1, 0, 0, 8'h00, 0);
    chk(out_a_valid == 0, "R1", out_a_valid, 0);
    chk(out_b_valid == 0, "R1", out_b_valid, 0);
    chk({en_a, en_b, en_c} == 3'b000, "R1", {en_a, en_b, en_c}, 0);
    chk(req_ready == 1, "R1", req_ready, 1);
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    bit f;
    for (int c = 0; c < 3; c++) cyc(1, 0, 0, 8'h00, 1);
    r1_after_reset();
    for (int c = 0; c < 40; c++) cyc(1, 1, 0, 8'($urandom), 0);
    for (int c = 0; c < 8; c++)  cyc(1, 0, 0, 8'h00, 0);
    for (int c = 0; c < 40; c++) cyc(1, 1, 1, 8'($urandom), 0);
    for (int c = 0; c < 8; c++)  cyc(1, 0, 0, 8'h00, 0);
    for (int c = 0; c < 250; c++)
      cyc(1, ($urandom % 10) < 7, 1'($urandom), 8'($urandom), 0);
    cyc(1, 0, 0, 8'h00, 1);
    cyc(1, 0, 0, 8'h00, 1);
    r1_after_reset();
    f = 1'b1;
    for (int c = 0; c < 300; c++) begin
      if (($urandom % 8) == 0) f = ~f;
      cyc(0, ($urandom % 10) < 8, f, 8'($urandom), 0);
    end
    for (int c = 0; c < 10; c++) cyc(0, 0, 0, 8'h00, 0);
    summary();
    $finish;
  end
endmodule